// File: doc/BRIEF.md
# Nibble Add/Subtract Datapath with Carry Flag

This block is a small 4-bit arithmetic datapath. Two working registers, here called the A register and the B register, feed a combined adder/subtractor at all times: the A register drives the first operand and the B register the second. The result of that unit, or a 4-bit immediate supplied by the controlling logic, can be written back into either working register. A third register holds a result for outside use and is loaded only from the A register.

A 2-bit destination code chooses which register, if any, captures on the next rising clock edge, and a one-bit flag register stores the carry-out of the arithmetic unit on every edge. Sequencing and instruction fetch live outside; the surrounding controller simply drives the destination code, the source select, the add/subtract select and the immediate value once per cycle.

Top module: `nibble_dp`

## Requirements
- R1: While the reset input is low, and for two clock edges after it is released, `ra_q`, `rb_q`, `ro_q` and `carry_q` read zero.
- R2: With `sub_mode` = 0, `alu_y` equals (`ra_q` + `rb_q`) mod 16, combinationally.
- R3: With `sub_mode` = 1, `alu_y` equals (`ra_q` − `rb_q`) mod 16, formed by inverting each bit of the second operand and injecting a carry-in of 1.
- R4: On every rising edge, whatever the destination code, `carry_q` takes the arithmetic carry-out: for addition 1 when `ra_q` + `rb_q` ≥ 16; for subtraction 1 when no borrow occurs (`ra_q` ≥ `rb_q`).
- R5: Destination code 2'b00 writes the A register; with any other code `ra_q` holds.
- R6: Destination code 2'b01 writes the B register; with any other code `rb_q` holds.
- R7: Destination code 2'b10 copies the current `ra_q` into `ro_q`, regardless of `sel_imm` and `imm`; with any other code `ro_q` holds.
- R8: Destination code 2'b11 writes none of the three data registers.
- R9: The write data is `imm` when `sel_imm` = 1 and `alu_y` when `sel_imm` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dst_addr | input | 2 | Destination code: 00 A, 01 B, 10 output register, 11 none |
| sel_imm | input | 1 | Write data source: 1 immediate, 0 arithmetic result |
| sub_mode | input | 1 | 0 add, 1 subtract |
| imm | input | 4 | Immediate write value |
| ra_q | output | 4 | A register contents |
| rb_q | output | 4 | B register contents |
| ro_q | output | 4 | Output register contents |
| alu_y | output | 4 | Combinational arithmetic result |
| carry_q | output | 1 | Registered carry-out |

## Verification
The assertions take for granted that every control and data input is a known value and settles before each rising edge, so the registered carry and write-back can be compared with the port values one cycle earlier. Since the destination code is two bits wide, all four codes are legal and the stimulus covers each of them. The bench changes inputs only on falling edges, drawing them from a fixed-seed random source mixed with directed cases for wrap-around, borrow, equal operands and the register swap sequence.

// File: rtl/nibble_dp_pkg.sv
package nibble_dp_pkg;
  typedef enum logic [1:0] {
    DST_RA   = 2'b00,
    DST_RB   = 2'b01,
    DST_RO   = 2'b10,
    DST_NONE = 2'b11
  } dst_e;

  localparam int NUM_DST = 3;
endpackage

// File: rtl/nibble_addsub.sv
module nibble_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         cout
);
  logic [W-1:0] b_inv;
  logic [W:0]   sum;

  always_comb begin
    b_inv = b ^ {W{sub}};
    sum   = {1'b0, a} + {1'b0, b_inv} + {{W{1'b0}}, sub};
    y     = sum[W-1:0];
    cout  = sum[W];
  end
endmodule

// File: rtl/nibble_wr_decode.sv
module nibble_wr_decode
  import nibble_dp_pkg::*;
#(
  parameter int N = NUM_DST
) (
  input  logic [1:0]   code,
  output logic [N-1:0] we
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign we[i] = (code == 2'(i));
  end
endmodule

// File: rtl/nibble_reg.sv
module nibble_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/nibble_dp.sv
module nibble_dp
  import nibble_dp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   dst_addr,
  input  logic         sel_imm,
  input  logic         sub_mode,
  input  logic [W-1:0] imm,
  output logic [W-1:0] ra_q,
  output logic [W-1:0] rb_q,
  output logic [W-1:0] ro_q,
  output logic [W-1:0] alu_y,
  output logic         carry_q
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_n_sync;
  logic [NUM_DST-1:0]     we;
  logic [W-1:0]           wr_data;
  logic                   cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = sync_q[SYNC_STAGES-1];

  nibble_addsub #(.W(W)) u_alu (
    .a    (ra_q),
    .b    (rb_q),
    .sub  (sub_mode),
    .y    (alu_y),
    .cout (cout)
  );

  nibble_wr_decode #(.N(NUM_DST)) u_dec (
    .code (dst_addr),
    .we   (we)
  );

  always_comb begin
    wr_data = sel_imm ? imm : alu_y;
  end

  nibble_reg #(.W(W)) u_ra (
    .clk (clk), .rst_n (rst_n_sync), .en (we[DST_RA]), .d (wr_data), .q (ra_q)
  );

  nibble_reg #(.W(W)) u_rb (
    .clk (clk), .rst_n (rst_n_sync), .en (we[DST_RB]), .d (wr_data), .q (rb_q)
  );

  nibble_reg #(.W(W)) u_ro (
    .clk (clk), .rst_n (rst_n_sync), .en (we[DST_RO]), .d (ra_q), .q (ro_q)
  );

  nibble_reg #(.W(1)) u_cy (
    .clk (clk), .rst_n (rst_n_sync), .en (1'b1), .d (cout), .q (carry_q)
  );
endmodule

// File: rtl/nibble_dp_chk.sv
module nibble_dp_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_ok,
  input logic [1:0]   dst_addr,
  input logic         sel_imm,
  input logic         sub_mode,
  input logic [W-1:0] imm,
  input logic [W-1:0] ra_q,
  input logic [W-1:0] rb_q,
  input logic [W-1:0] ro_q,
  input logic [W-1:0] alu_y,
  input logic         carry_q
);
  logic exp_carry;

  always_comb begin
    if (sub_mode) exp_carry = (ra_q >= rb_q);
    else          exp_carry = ({1'b0, ra_q} + {1'b0, rb_q}) > (W+1)'((1 << W) - 1);
  end

  assert_add_result_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !sub_mode |-> alu_y == W'(ra_q + rb_q));

  assert_sub_result_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    sub_mode |-> alu_y == W'(ra_q - rb_q));

  assert_carry_capture_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_ok |=> carry_q == $past(exp_carry));

  assert_ra_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    dst_addr != 2'b00 |=> $stable(ra_q));

  assert_rb_hold_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    dst_addr != 2'b01 |=> $stable(rb_q));

  assert_ro_copy_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    dst_addr == 2'b10 |=> ro_q == $past(ra_q));

  assert_no_write_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    dst_addr == 2'b11 |=> $stable(ra_q) && $stable(rb_q) && $stable(ro_q));

  assert_imm_source_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (dst_addr == 2'b00 && sel_imm) |=> ra_q == $past(imm));
endmodule

bind nibble_dp nibble_dp_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_n_sync),
  .dst_addr (dst_addr),
  .sel_imm  (sel_imm),
  .sub_mode (sub_mode),
  .imm      (imm),
  .ra_q     (ra_q),
  .rb_q     (rb_q),
  .ro_q     (ro_q),
  .alu_y    (alu_y),
  .carry_q  (carry_q)
);

// File: tb/nibble_dp_test.sv
`timescale 1ns/1ps
module nibble_dp_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   dst_addr;
  logic         sel_imm;
  logic         sub_mode;
  logic [W-1:0] imm;
  logic [W-1:0] ra_q, rb_q, ro_q, alu_y;
  logic         carry_q;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] m_ra, m_rb, m_ro;
  logic         m_c;

  always #2 clk = ~clk;

  nibble_dp #(.W(W)) uut (
    .clk (clk), .rst_n (rst_n), .dst_addr (dst_addr), .sel_imm (sel_imm),
    .sub_mode (sub_mode), .imm (imm), .ra_q (ra_q), .rb_q (rb_q),
    .ro_q (ro_q), .alu_y (alu_y), .carry_q (carry_q)
  );

  function automatic logic [W-1:0] f_result(logic [W-1:0] a, logic [W-1:0] b, logic s);
    int r;
    r = s ? (int'(a) - int'(b)) : (int'(a) + int'(b));
    return W'(r & ((1 << W) - 1));
  endfunction

  function automatic logic f_carry(logic [W-1:0] a, logic [W-1:0] b, logic s);
    if (s) return int'(a) >= int'(b);
    return (int'(a) + int'(b)) >= (1 << W);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] a, logic s_imm, logic sub, logic [W-1:0] v);
    logic [W-1:0] res, wd;
    @(negedge clk);
    dst_addr = a; sel_imm = s_imm; sub_mode = sub; imm = v;
    #1;
    res = f_result(m_ra, m_rb, sub);
    chk(sub ? "R3 alu_y" : "R2 alu_y", int'(alu_y), int'(res));
    wd = s_imm ? v : res;
    m_c = f_carry(m_ra, m_rb, sub);
    case (a)
      2'b00: m_ra = wd;
      2'b01: m_rb = wd;
      2'b10: m_ro = m_ra;
      default: ;
    endcase
    @(posedge clk);
    #1;
    chk("R4 carry_q", int'(carry_q), int'(m_c));
    chk(a == 2'b00 ? (s_imm ? "R9 ra_q" : "R5 ra_q") : (a == 2'b11 ? "R8 ra_q" : "R5 ra_q"),
        int'(ra_q), int'(m_ra));
    chk(a == 2'b01 ? "R6 rb_q" : (a == 2'b11 ? "R8 rb_q" : "R6 rb_q"), int'(rb_q), int'(m_rb));
    chk(a == 2'b10 ? "R7 ro_q" : (a == 2'b11 ? "R8 ro_q" : "R7 ro_q"), int'(ro_q), int'(m_ro));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed_0017);
    rst_n = 1'b0; dst_addr = 2'b00; sel_imm = 1'b1; sub_mode = 1'b0; imm = 4'd9;
    m_ra = '0; m_rb = '0; m_ro = '0; m_c = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ra_q", int'(ra_q), 0);
    chk("R1 rb_q", int'(rb_q), 0);
    chk("R1 ro_q", int'(ro_q), 0);
    chk("R1 carry_q", int'(carry_q), 0);
    @(negedge clk);
    dst_addr = 2'b11; sel_imm = 1'b0; imm = '0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ra_q after release", int'(ra_q), 0);

    // swap sequence: A=2, B=3, A=A+B, B=A-B, A=A-B
    step(2'b00, 1'b1, 1'b0, 4'd2);
    step(2'b01, 1'b1, 1'b0, 4'd3);
    step(2'b00, 1'b0, 1'b0, 4'd0);
    step(2'b01, 1'b0, 1'b1, 4'd0);
    step(2'b00, 1'b0, 1'b1, 4'd0);
    chk("R3 swap A", int'(ra_q), 3);
    chk("R3 swap B", int'(rb_q), 2);
    // RO copy ignoring immediate source
    step(2'b10, 1'b1, 1'b0, 4'd12);
    // wrap: 15 + 1
    step(2'b00, 1'b1, 1'b0, 4'd15);
    step(2'b01, 1'b1, 1'b0, 4'd1);
    step(2'b11, 1'b0, 1'b0, 4'd7);
    // borrow: 0 - 1, then equal operands
    step(2'b00, 1'b1, 1'b0, 4'd0);
    step(2'b11, 1'b1, 1'b1, 4'd5);
    step(2'b00, 1'b1, 1'b0, 4'd1);
    step(2'b11, 1'b0, 1'b1, 4'd0);
    // carry updates while writing RO
    step(2'b10, 1'b0, 1'b1, 4'd3);

    for (int i = 0; i < 500; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0], r[2], r[3], r[7:4]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule